// File: doc/BRIEF.md
# Virtualization Mode Controller

This block tracks the virtualization mode of one logical processor. There are three modes. The processor is either outside the extension, in host (root) mode, or in guest (non-root) mode. An upstream decoder sends one-cycle strobes for the enable, disable, launch, resume and guest-hypercall instructions. The block also receives three kinds of event:

- an INIT request;
- an address-wrap (A20 mask) condition;
- control-register write attempts.

It also watches the live values of two control registers, called control word A and control word B.

Each instruction or event may move the mode. The block reports what happened with registered one-cycle pulses:

- success;
- failure;
- guest exit, together with a reason code;
- general-protection fault.

Inside the extension the block holds INIT pending while in host mode. A pending INIT forces a guest exit as soon as the guest runs. The block also suppresses the address-wrap mask while the extension is active.

The block only sequences modes and checks legality. Decoding, control-structure contents, memory traffic and state save or restore belong to other units.

Top module: `vmode_ctrl`

## Requirements
- R1: After synchronous reset, `mode` is 0 (outside), `init_held` is 0, and every pulse output is 0.
- R2: In mode 0, a legal enable moves the block to mode 1 (host) and pulses `ok_pulse` one cycle after the strobe. A disable in mode 1 returns the block to mode 0 with `ok_pulse`.
- R3: An enable fails in each of these cases: control word A lacks any of bits 0, 5 or 31, or control word B lacks bit 13. A failed enable pulses `fail_pulse` and leaves `mode` at 0.
- R4: An enable also fails while `a20_req` is high. `a20_apply` follows `a20_req` only while `mode` is 0 and stays 0 in modes 1 and 2.
- R5: In mode 1, a launch or resume with `ctx_valid` high moves the block to mode 2 (guest) with `ok_pulse`. With `ctx_valid` low, the same strobe gives `fail_pulse` and the mode stays at 1.
- R6: The following strobes pulse `fail_pulse` and leave `mode` unchanged:
  - launch, resume or disable in mode 0;
  - any of those three in mode 2;
  - enable in mode 1 or mode 2;
  - hypercall in mode 1.
- R7: A hypercall in mode 2 pulses `exit_pulse` with `exit_code` 1 and returns the block to mode 1.
- R8: `ext_exit_req` in mode 2 pulses `exit_pulse` with `exit_code` 2 and returns the block to mode 1.
- R9: An INIT in mode 2 pulses `exit_pulse` with `exit_code` 0 and returns the block to mode 1. INIT takes priority over a hypercall and over an external exit request in the same cycle.
- R10: An INIT in mode 1 sets `init_held` and causes no exit or mode change. A held INIT forces an exit with code 0 in the first cycle the block spends in mode 2. An INIT (held or new) seen in mode 0 pulses `init_deliver` and clears `init_held`.
- R11: A write attempt (`cr_wr_req`) in mode 1 or mode 2 pulses `gp_pulse` when its data lacks a required bit of the selected word. `cr_wr_sel` selects the word: 0 for control word A, 1 for control word B. A legal write, or any write in mode 0, gives no `gp_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_enable | input | 1 | Enable-instruction strobe |
| op_disable | input | 1 | Disable-instruction strobe |
| op_launch | input | 1 | Launch-instruction strobe |
| op_resume | input | 1 | Resume-instruction strobe |
| op_hypercall | input | 1 | Guest hypercall strobe |
| ctx_valid | input | 1 | A current control structure is loaded |
| ext_exit_req | input | 1 | External request to leave the guest |
| init_req | input | 1 | INIT event strobe |
| a20_req | input | 1 | Address-wrap mask condition (level) |
| cr_wr_req | input | 1 | Control-register write attempt |
| cr_wr_sel | input | 1 | Target of the write: 0 = word A, 1 = word B |
| cr_wr_data | input | CW | Value the write would store |
| ctl_a | input | CW | Current control word A |
| ctl_b | input | CW | Current control word B |
| mode | output | 2 | 0 outside, 1 host, 2 guest |
| ok_pulse | output | 1 | Instruction succeeded |
| fail_pulse | output | 1 | Instruction failed |
| exit_pulse | output | 1 | Guest exit taken |
| exit_code | output | 2 | Exit reason: 0 INIT, 1 hypercall, 2 external |
| gp_pulse | output | 1 | General-protection fault on an illegal write |
| init_held | output | 1 | An INIT is pending |
| init_deliver | output | 1 | INIT acted on outside the extension |
| a20_apply | output | 1 | Address-wrap mask is in effect |

## Verification
The hardest situation to reach is an INIT that arrives in host mode and is carried into the guest. It must fire as a code-0 exit in the first guest cycle, with no new INIT on the pins. A second variant carries the pending INIT out through a disable instead, where it must appear as a delivery pulse.

The stimulus reaches both cases in the same way. It pulses INIT while in host mode and confirms that `init_held` rises with no exit. It then issues either a launch or a disable, and follows with an idle cycle in which the scoreboard expects the deferred effect. It also stacks INIT, a hypercall and an external request in one guest cycle to confirm the priority order.

// File: rtl/vmode_pkg.sv
package vmode_pkg;

    typedef enum logic [1:0] {
        M_OFF   = 2'd0,
        M_HOST  = 2'd1,
        M_GUEST = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        X_INIT  = 2'd0,
        X_HCALL = 2'd1,
        X_EXT   = 2'd2
    } exit_e;

    typedef struct packed {
        logic en;
        logic dis;
        logic lau;
        logic res;
        logic hyp;
    } op_t;

    typedef struct packed {
        logic  ok;
        logic  fail;
        logic  exit_v;
        exit_e code;
        logic  gp;
    } result_t;

    localparam result_t RESULT_IDLE = '{ok: 1'b0, fail: 1'b0, exit_v: 1'b0, code: X_INIT, gp: 1'b0};

endpackage

// File: rtl/vmode_legal.sv
module vmode_legal #(
    parameter int          CW    = 32,
    parameter logic [CW-1:0] REQ_A = 32'h8000_0021,
    parameter logic [CW-1:0] REQ_B = 32'h0000_2000
) (
    input  logic [CW-1:0] ctl_a,
    input  logic [CW-1:0] ctl_b,
    input  logic          a20_req,
    input  logic          wr_sel,
    input  logic [CW-1:0] wr_data,
    output logic          enable_ok,
    output logic          wr_illegal
);
    localparam int NWORD = 2;

    logic [CW-1:0] word_val [NWORD];
    logic [CW-1:0] word_req [NWORD];
    logic [NWORD-1:0] word_good;

    assign word_val[0] = ctl_a;
    assign word_val[1] = ctl_b;
    assign word_req[0] = REQ_A;
    assign word_req[1] = REQ_B;

    for (genvar g = 0; g < NWORD; g++) begin : g_word
        assign word_good[g] = ((word_val[g] & word_req[g]) == word_req[g]);
    end

    assign enable_ok  = (&word_good) && !a20_req;
    assign wr_illegal = ((wr_data & word_req[wr_sel]) != word_req[wr_sel]);

endmodule

// File: rtl/vmode_init_track.sv
module vmode_init_track
    import vmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode_q,
    input  logic  init_req,
    input  logic  consume,
    output logic  held_q,
    output logic  deliver_q
);
    logic held_d;
    logic deliver_d;

    always_comb begin
        held_d    = held_q;
        deliver_d = 1'b0;
        if (mode_q == M_HOST && init_req) begin
            held_d = 1'b1;
        end else if (consume) begin
            held_d = 1'b0;
        end else if (mode_q == M_OFF) begin
            deliver_d = init_req || held_q;
            held_d    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q    <= 1'b0;
            deliver_q <= 1'b0;
        end else begin
            held_q    <= held_d;
            deliver_q <= deliver_d;
        end
    end

    AST_HOLD_FROM_HOST: assert property (@(posedge clk) disable iff (rst)
        $rose(held_q) |-> $past(mode_q) == M_HOST); // R10

    AST_HOLD_CLEARED_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_OFF && !init_req) |=> !held_q); // R10

endmodule

// File: rtl/vmode_fsm.sv
module vmode_fsm
    import vmode_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  op_t     op,
    input  logic    ctx_valid,
    input  logic    ext_exit_req,
    input  logic    init_now,
    input  logic    enable_ok,
    input  logic    cr_wr_req,
    input  logic    wr_illegal,
    output mode_e   mode_q,
    output result_t res_q,
    output logic    consume
);
    mode_e   mode_d;
    result_t res_d;

    assign consume = (mode_q == M_GUEST) && init_now;

    always_comb begin
        mode_d = mode_q;
        res_d  = RESULT_IDLE;
        unique case (mode_q)
            M_OFF: begin
                if (op.en) begin
                    if (enable_ok) begin
                        mode_d   = M_HOST;
                        res_d.ok = 1'b1;
                    end else begin
                        res_d.fail = 1'b1;
                    end
                end else if (op.dis || op.lau || op.res) begin
                    res_d.fail = 1'b1;
                end
            end
            M_HOST: begin
                if (op.dis) begin
                    mode_d   = M_OFF;
                    res_d.ok = 1'b1;
                end else if (op.lau || op.res) begin
                    if (ctx_valid) begin
                        mode_d   = M_GUEST;
                        res_d.ok = 1'b1;
                    end else begin
                        res_d.fail = 1'b1;
                    end
                end else if (op.en || op.hyp) begin
                    res_d.fail = 1'b1;
                end
            end
            M_GUEST: begin
                if (init_now) begin
                    mode_d       = M_HOST;
                    res_d.exit_v = 1'b1;
                    res_d.code   = X_INIT;
                end else if (op.hyp) begin
                    mode_d       = M_HOST;
                    res_d.exit_v = 1'b1;
                    res_d.code   = X_HCALL;
                end else if (ext_exit_req) begin
                    mode_d       = M_HOST;
                    res_d.exit_v = 1'b1;
                    res_d.code   = X_EXT;
                end else if (op.en || op.dis || op.lau || op.res) begin
                    res_d.fail = 1'b1;
                end
            end
            default: mode_d = M_OFF;
        endcase
        res_d.gp = cr_wr_req && wr_illegal && (mode_q != M_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_OFF;
            res_q  <= RESULT_IDLE;
        end else begin
            mode_q <= mode_d;
            res_q  <= res_d;
        end
    end

    AST_BAD_ENABLE_STAYS_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_OFF && op.en && !enable_ok) |=> (mode_q == M_OFF && res_q.fail)); // R3

    AST_GUEST_VIA_HOST: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_GUEST) |-> ($past(mode_q) != M_OFF)); // R5

    AST_EXIT_LANDS_HOST: assert property (@(posedge clk) disable iff (rst)
        res_q.exit_v |-> (mode_q == M_HOST)); // R7

    AST_INIT_WINS: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_GUEST && init_now) |=> (res_q.exit_v && res_q.code == X_INIT)); // R9

    AST_GP_ONLY_INSIDE: assert property (@(posedge clk) disable iff (rst)
        res_q.gp |-> ($past(mode_q) != M_OFF)); // R11

    AST_OK_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(res_q.ok && res_q.fail)); // R2

endmodule

// File: rtl/vmode_ctrl.sv
module vmode_ctrl
    import vmode_pkg::*;
#(
    parameter int            CW    = 32,
    parameter logic [CW-1:0] REQ_A = 32'h8000_0021,
    parameter logic [CW-1:0] REQ_B = 32'h0000_2000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_enable,
    input  logic          op_disable,
    input  logic          op_launch,
    input  logic          op_resume,
    input  logic          op_hypercall,
    input  logic          ctx_valid,
    input  logic          ext_exit_req,
    input  logic          init_req,
    input  logic          a20_req,
    input  logic          cr_wr_req,
    input  logic          cr_wr_sel,
    input  logic [CW-1:0] cr_wr_data,
    input  logic [CW-1:0] ctl_a,
    input  logic [CW-1:0] ctl_b,
    output logic [1:0]    mode,
    output logic          ok_pulse,
    output logic          fail_pulse,
    output logic          exit_pulse,
    output logic [1:0]    exit_code,
    output logic          gp_pulse,
    output logic          init_held,
    output logic          init_deliver,
    output logic          a20_apply
);
    op_t     op;
    mode_e   mode_q;
    result_t res_q;
    logic    enable_ok;
    logic    wr_illegal;
    logic    consume;
    logic    held_q;

    assign op = '{en: op_enable, dis: op_disable, lau: op_launch,
                  res: op_resume, hyp: op_hypercall};

    vmode_legal #(.CW(CW), .REQ_A(REQ_A), .REQ_B(REQ_B)) u_legal (
        .ctl_a      (ctl_a),
        .ctl_b      (ctl_b),
        .a20_req    (a20_req),
        .wr_sel     (cr_wr_sel),
        .wr_data    (cr_wr_data),
        .enable_ok  (enable_ok),
        .wr_illegal (wr_illegal)
    );

    vmode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .op           (op),
        .ctx_valid    (ctx_valid),
        .ext_exit_req (ext_exit_req),
        .init_now     (init_req || held_q),
        .enable_ok    (enable_ok),
        .cr_wr_req    (cr_wr_req),
        .wr_illegal   (wr_illegal),
        .mode_q       (mode_q),
        .res_q        (res_q),
        .consume      (consume)
    );

    vmode_init_track u_init (
        .clk       (clk),
        .rst       (rst),
        .mode_q    (mode_q),
        .init_req  (init_req),
        .consume   (consume),
        .held_q    (held_q),
        .deliver_q (init_deliver)
    );

    assign mode       = mode_q;
    assign ok_pulse   = res_q.ok;
    assign fail_pulse = res_q.fail;
    assign exit_pulse = res_q.exit_v;
    assign exit_code  = res_q.code;
    assign gp_pulse   = res_q.gp;
    assign init_held  = held_q;
    assign a20_apply  = a20_req && (mode_q == M_OFF);

    AST_NO_DELIVER_INSIDE: assert property (@(posedge clk) disable iff (rst)
        init_deliver |-> ($past(mode_q) == M_OFF)); // R10

endmodule

// File: tb/vmode_ctrl_tb.sv
`timescale 1ns/1ps
module vmode_ctrl_tb;

    localparam logic [31:0] MA = 32'h8000_0021;
    localparam logic [31:0] MB = 32'h0000_2000;

    typedef struct {
        bit en, dis, lau, res, hyp, ctx, ext, init, a20, crw, sel;
        logic [31:0] data, a, b;
    } stim_t;

    typedef struct {
        string tag;
        int    m;
        bit    ok, fail, ex, gp, held, dl, a20;
        int    code;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_enable, op_disable, op_launch, op_resume, op_hypercall;
    logic ctx_valid, ext_exit_req, init_req, a20_req, cr_wr_req, cr_wr_sel;
    logic [31:0] cr_wr_data, ctl_a, ctl_b;
    logic [1:0] mode, exit_code;
    logic ok_pulse, fail_pulse, exit_pulse, gp_pulse, init_held, init_deliver, a20_apply;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t q[$];
    int  m_mode = 0;
    bit  m_held = 1'b0;

    always #4 clk = ~clk;

    vmode_ctrl u_dut (
        .clk(clk), .rst(rst),
        .op_enable(op_enable), .op_disable(op_disable), .op_launch(op_launch),
        .op_resume(op_resume), .op_hypercall(op_hypercall), .ctx_valid(ctx_valid),
        .ext_exit_req(ext_exit_req), .init_req(init_req), .a20_req(a20_req),
        .cr_wr_req(cr_wr_req), .cr_wr_sel(cr_wr_sel), .cr_wr_data(cr_wr_data),
        .ctl_a(ctl_a), .ctl_b(ctl_b),
        .mode(mode), .ok_pulse(ok_pulse), .fail_pulse(fail_pulse),
        .exit_pulse(exit_pulse), .exit_code(exit_code), .gp_pulse(gp_pulse),
        .init_held(init_held), .init_deliver(init_deliver), .a20_apply(a20_apply)
    );

    function automatic stim_t idle();
        stim_t s;
        s = '{default: 0};
        s.a = MA;
        s.b = MB;
        s.data = MA;
        return s;
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic apply(input string tag, input stim_t s);
        exp_t e;
        bit legal, init_now;
        int nm;
        @(negedge clk);
        op_enable = s.en; op_disable = s.dis; op_launch = s.lau; op_resume = s.res;
        op_hypercall = s.hyp; ctx_valid = s.ctx; ext_exit_req = s.ext; init_req = s.init;
        a20_req = s.a20; cr_wr_req = s.crw; cr_wr_sel = s.sel; cr_wr_data = s.data;
        ctl_a = s.a; ctl_b = s.b;
        e = '{tag: tag, m: 0, ok: 0, fail: 0, ex: 0, gp: 0, held: 0, dl: 0, a20: 0, code: 0};
        legal = ((s.a & MA) == MA) && ((s.b & MB) == MB) && !s.a20;
        init_now = s.init || m_held;
        nm = m_mode;
        case (m_mode)
            0: begin
                if (s.en) begin
                    if (legal) begin nm = 1; e.ok = 1; end else e.fail = 1;
                end else if (s.dis || s.lau || s.res) e.fail = 1;
            end
            1: begin
                if (s.dis) begin nm = 0; e.ok = 1; end
                else if (s.lau || s.res) begin
                    if (s.ctx) begin nm = 2; e.ok = 1; end else e.fail = 1;
                end else if (s.en || s.hyp) e.fail = 1;
            end
            default: begin
                if (init_now)      begin nm = 1; e.ex = 1; e.code = 0; end
                else if (s.hyp)    begin nm = 1; e.ex = 1; e.code = 1; end
                else if (s.ext)    begin nm = 1; e.ex = 1; e.code = 2; end
                else if (s.en || s.dis || s.lau || s.res) e.fail = 1;
            end
        endcase
        e.gp = s.crw && (m_mode != 0) &&
               (s.sel ? ((s.data & MB) != MB) : ((s.data & MA) != MA));
        if (m_mode == 1 && s.init) m_held = 1'b1;
        else if (m_mode == 2 && init_now) m_held = 1'b0;
        else if (m_mode == 0) begin e.dl = init_now; m_held = 1'b0; end
        m_mode = nm;
        e.m = nm;
        e.held = m_held;
        e.a20 = s.a20 && (nm == 0);
        q.push_back(e);
    endtask

    // Monitor: compares each cycle's outputs against the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (mode !== e.m[1:0] || ok_pulse !== e.ok || fail_pulse !== e.fail ||
                    exit_pulse !== e.ex || gp_pulse !== e.gp || init_held !== e.held ||
                    init_deliver !== e.dl || a20_apply !== e.a20 ||
                    (e.ex && exit_code !== e.code[1:0])) begin
                    failures++;
                    $display("FAIL %s: act mode=%0d ok=%0b fail=%0b exit=%0b code=%0d gp=%0b held=%0b dl=%0b a20=%0b exp mode=%0d ok=%0b fail=%0b exit=%0b code=%0d gp=%0b held=%0b dl=%0b a20=%0b",
                        e.tag, mode, ok_pulse, fail_pulse, exit_pulse, exit_code, gp_pulse,
                        init_held, init_deliver, a20_apply,
                        e.m, e.ok, e.fail, e.ex, e.code, e.gp, e.held, e.dl, e.a20);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        stim_t s;
        s = idle();
        op_enable = 0; op_disable = 0; op_launch = 0; op_resume = 0; op_hypercall = 0;
        ctx_valid = 0; ext_exit_req = 0; init_req = 0; a20_req = 0; cr_wr_req = 0;
        cr_wr_sel = 0; cr_wr_data = MA; ctl_a = MA; ctl_b = MB;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        checks++;
        if (mode !== 2'd0 || init_held !== 1'b0 || ok_pulse || fail_pulse ||
            exit_pulse || gp_pulse || init_deliver) begin
            failures++;
            $display("FAIL R1: act mode=%0d held=%0b exp mode=0 held=0", mode, init_held);
        end

        // R3 each required bit missing
        s = idle(); s.en = 1; s.a = MA & ~32'h1;          apply("R3 A bit0", s);
        s = idle(); s.en = 1; s.a = MA & ~32'h20;         apply("R3 A bit5", s);
        s = idle(); s.en = 1; s.a = MA & ~32'h8000_0000;  apply("R3 A bit31", s);
        s = idle(); s.en = 1; s.b = 32'hFFFF_DFFF;        apply("R3 B bit13", s);
        // R4 address-wrap blocks enable; mask applied outside
        s = idle(); s.en = 1; s.a20 = 1;                  apply("R4 enable with a20", s);
        // R6 outside: launch/resume/disable fail
        s = idle(); s.lau = 1; s.ctx = 1;                 apply("R6 launch outside", s);
        s = idle(); s.dis = 1;                            apply("R6 disable outside", s);
        // R11 write outside gives no fault
        s = idle(); s.crw = 1; s.data = 0;                apply("R11 write outside", s);
        // R10 INIT outside delivered
        s = idle(); s.init = 1;                           apply("R10 init outside", s);
        s = idle();                                       apply("R10 deliver pulse", s);
        // R2 legal enable
        s = idle(); s.en = 1; s.a = 32'hFFFF_FFFF;        apply("R2 enable", s);
        s = idle(); s.a20 = 1;                            apply("R4 a20 blocked in host", s);
        s = idle(); s.en = 1;                             apply("R6 enable in host", s);
        s = idle(); s.hyp = 1;                            apply("R6 hypercall in host", s);
        // R5 launch needs a current structure
        s = idle(); s.lau = 1;                            apply("R5 launch no ctx", s);
        s = idle(); s.res = 1; s.ctx = 1;                 apply("R5 resume ctx", s);
        // R6 strobes in guest
        s = idle(); s.lau = 1; s.ctx = 1;                 apply("R6 launch in guest", s);
        s = idle(); s.en = 1;                             apply("R6 enable in guest", s);
        // R11 faults in guest and host
        s = idle(); s.crw = 1; s.sel = 1; s.data = 32'h0; apply("R11 guest B illegal", s);
        s = idle(); s.crw = 1; s.sel = 1; s.data = MB;    apply("R11 guest B legal", s);
        // R7 hypercall exit
        s = idle(); s.hyp = 1;                            apply("R7 hypercall exit", s);
        s = idle(); s.crw = 1; s.sel = 0; s.data = MA & ~32'h20; apply("R11 host A illegal", s);
        s = idle(); s.lau = 1; s.ctx = 1;                 apply("R5 launch ctx", s);
        // R8 external exit
        s = idle(); s.ext = 1;                            apply("R8 external exit", s);
        s = idle(); s.res = 1; s.ctx = 1;                 apply("R5 re-entry", s);
        // R9 INIT priority
        s = idle(); s.init = 1; s.hyp = 1; s.ext = 1;     apply("R9 init priority", s);
        // R10 held INIT carried into guest
        s = idle(); s.init = 1;                           apply("R10 init held in host", s);
        s = idle();                                       apply("R10 still held", s);
        s = idle(); s.lau = 1; s.ctx = 1;                 apply("R10 enter with held", s);
        s = idle();                                       apply("R10 held forces exit", s);
        // R10 held INIT released through disable
        s = idle(); s.init = 1;                           apply("R10 hold again", s);
        s = idle(); s.dis = 1;                            apply("R2 disable", s);
        s = idle(); s.a20 = 1;                            apply("R10 deliver after disable", s);
        s = idle();                                       apply("R1 quiet", s);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule